// File: doc/BRIEF.md
# Reset Sequencer with Stabilization Counter

This block decides when a small microcontroller is held in reset and when it is let go. Three kinds of fault can request a reset: a power-on event, a supply dip reported by a low-voltage comparator, and an instruction fetch from an address that has no memory behind it. A fourth request comes from outside the chip, when the reset pin is pulled low. For every internal fault the block pulls the shared reset pin low through a drive-low enable. It keeps the CPU in reset separately from the pin. It records each cause in a readable status byte.

All timing comes from one 12-bit counter that advances on the falling edge of the crystal clock. When the last fault goes away, the block keeps the pin low for one full counter period. It then releases the pin and opens the internal bus clocks. A further 64 cycles later it releases the CPU so the reset vector can be fetched. The same counter times the oscillator restart when the part leaves stop mode. Each counter wrap gives a one-cycle tick that acts as the watchdog prescaler output.

Top module: `resetSequencer`

## Requirements
- R1: All state advances on the falling edge of `xclk`. The 12-bit stabilization counter is held at zero on every edge where a reset source is active, and it advances by one on every other edge, except while stopped.
- R2: `copTick` is high for exactly one cycle, directly after the counter wraps from 4095 to 0. It never rises on an edge where the counter is cleared.
- R3: `rstPinDriveLow` is high while any reset source is active. It stays high for exactly 4096 falling edges after the last source clears, including after `porRst` falls.
- R4: `cpuRstN` rises exactly 64 falling edges after `rstPinDriveLow` falls. `cpuRstN` is never high while the pin is driven.
- R5: The low-voltage request counts only when `lviPwrDisable` and `lviRstDisable` are both 0. If either bit is 1, the request has no effect on the pin, the CPU reset or the status byte.
- R6: Status byte bit positions: bit 0 power-on, bit 1 low-voltage, bit 2 illegal fetch, bit 3 external pin, bits 7:4 read 0. `porRst` forces the byte to 0x01, clearing every other flag.
- R7: A `stsRead` strobe clears the status byte on that edge. A flag whose source is active on the same edge is still set afterwards.
- R8: An access with `accValid`, `accIsFetch` and `accUnmapped` all high is a reset source. An unmapped access with `accIsFetch` low is ignored.
- R9: A low level on `rstPinIn` is a reset source only while the block is not driving the pin itself.
- R10: In run state a `stopEnter` pulse turns `ibusClkEn` off and clears the counter. After `wakeUp`, `ibusClkEn` returns after 4096 falling edges. `cpuRstN` stays high throughout.
- R11: `ibusClkEn` is low while the pin is driven and high during the 64-cycle tail and in run state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xclk | input | 1 | Crystal-derived clock; falling edge is active |
| porRst | input | 1 | Power-on request, asynchronous, active high |
| lviTrip | input | 1 | Low-voltage comparator output |
| lviPwrDisable | input | 1 | Configuration: low-voltage module powered down |
| lviRstDisable | input | 1 | Configuration: low-voltage reset disabled |
| accValid | input | 1 | Bus access in progress this cycle |
| accIsFetch | input | 1 | Access is an instruction fetch |
| accUnmapped | input | 1 | Access address has no memory behind it |
| rstPinIn | input | 1 | Sampled level of the reset pin |
| stopEnter | input | 1 | Request to enter stop mode |
| wakeUp | input | 1 | Wake request out of stop mode |
| stsRead | input | 1 | Status byte read strobe, clears on read |
| rstPinDriveLow | output | 1 | Enable for the reset pin's pull-down |
| cpuRstN | output | 1 | CPU reset, active low |
| ibusClkEn | output | 1 | Internal bus clock enable |
| copTick | output | 1 | Watchdog prescaler tick, one cycle per wrap |
| stsData | output | 8 | Reset status byte |

## Verification
A counter that is not cleared when a fault arrives shows up as a pin release earlier than 4096 edges after the fault ends. It also moves the `copTick` pulses away from the 4096-cycle grid. A wrong sequencer state shows on `rstPinDriveLow`, `cpuRstN` or `ibusClkEn` at the very next falling edge. A corrupted flag shows on `stsData` right away, since the byte is visible at all times. The bench's reference model is compared on every clock, so any divergence is caught within one cycle of where it arises.

// File: rtl/rsqPkg.sv
package rsqPkg;
  typedef enum logic [2:0] {
    SQ_HOLD = 3'd0,
    SQ_TAIL = 3'd1,
    SQ_RUN  = 3'd2,
    SQ_STOP = 3'd3,
    SQ_WAKE = 3'd4
  } seqState_t;

  localparam int FLAG_POR = 0;
  localparam int FLAG_LVI = 1;
  localparam int FLAG_ILL = 2;
  localparam int FLAG_PIN = 3;
  localparam int FLAG_N   = 4;

  typedef struct packed {
    logic              cntClr;
    logic              cntInc;
    logic [FLAG_N-1:0] setMask;
    logic              stsClr;
  } seqStrobe_t;
endpackage

// File: rtl/rsqDatapath.sv
module rsqDatapath
  import rsqPkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int TAIL_LEN = 64,
  parameter int STS_W    = 8
) (
  input  logic             xclk,
  input  logic             porRst,
  input  seqStrobe_t       strobe,
  output logic             cntAtMax,
  output logic             cntAtTail,
  output logic             copTick,
  output logic [STS_W-1:0] stsData
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] TAIL_END = CNT_W'(TAIL_LEN - 1);

  logic [CNT_W-1:0]  cnt;
  logic [FLAG_N-1:0] flags;

  assign cntAtMax  = (cnt == CNT_MAX);
  assign cntAtTail = (cnt == TAIL_END);

  always_ff @(negedge xclk or posedge porRst) begin
    if (porRst) begin
      cnt     <= '0;
      copTick <= 1'b0;
    end else begin
      copTick <= strobe.cntInc && !strobe.cntClr && cntAtMax;
      if (strobe.cntClr)      cnt <= '0;
      else if (strobe.cntInc) cnt <= cnt + 1'b1;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < FLAG_N; gi++) begin : g_flag
      always_ff @(negedge xclk or posedge porRst) begin
        if (porRst) flags[gi] <= (gi == FLAG_POR);
        else        flags[gi] <= strobe.setMask[gi] | (flags[gi] & ~strobe.stsClr);
      end
    end
  endgenerate

  assign stsData = STS_W'(flags);

  a_r1_clear_zero: assert property (@(negedge xclk) disable iff (porRst)
    strobe.cntClr |=> (cnt == '0));
  a_r2_tick_after_wrap: assert property (@(negedge xclk) disable iff (porRst)
    copTick |-> (cnt == '0));
  a_r7_read_clears: assert property (@(negedge xclk) disable iff (porRst)
    (strobe.stsClr && strobe.setMask == '0) |=> (stsData == '0));
endmodule

// File: rtl/rsqControl.sv
module rsqControl
  import rsqPkg::*;
(
  input  logic       xclk,
  input  logic       porRst,
  input  logic       lviTrip,
  input  logic       lviPwrDisable,
  input  logic       lviRstDisable,
  input  logic       accValid,
  input  logic       accIsFetch,
  input  logic       accUnmapped,
  input  logic       rstPinIn,
  input  logic       stopEnter,
  input  logic       wakeUp,
  input  logic       stsRead,
  input  logic       cntAtMax,
  input  logic       cntAtTail,
  output seqStrobe_t strobe,
  output logic       rstPinDriveLow,
  output logic       cpuRstN,
  output logic       ibusClkEn
);
  seqState_t state, stateNext;
  logic srcLvi, srcIll, srcPin, anySrc;

  assign srcLvi = lviTrip && !lviPwrDisable && !lviRstDisable;
  assign srcIll = accValid && accIsFetch && accUnmapped;
  assign srcPin = !rstPinIn && (state != SQ_HOLD);
  assign anySrc = srcLvi || srcIll || srcPin;

  always_comb begin
    stateNext              = state;
    strobe                 = '0;
    strobe.stsClr          = stsRead;
    strobe.setMask[FLAG_LVI] = srcLvi;
    strobe.setMask[FLAG_ILL] = srcIll;
    strobe.setMask[FLAG_PIN] = srcPin;
    if (anySrc) begin
      stateNext     = SQ_HOLD;
      strobe.cntClr = 1'b1;
    end else begin
      unique case (state)
        SQ_HOLD: begin
          strobe.cntInc = 1'b1;
          if (cntAtMax) stateNext = SQ_TAIL;
        end
        SQ_TAIL: begin
          strobe.cntInc = 1'b1;
          if (cntAtTail) stateNext = SQ_RUN;
        end
        SQ_RUN: begin
          if (stopEnter) begin
            stateNext     = SQ_STOP;
            strobe.cntClr = 1'b1;
          end else begin
            strobe.cntInc = 1'b1;
          end
        end
        SQ_STOP: begin
          strobe.cntClr = 1'b1;
          if (wakeUp) stateNext = SQ_WAKE;
        end
        SQ_WAKE: begin
          strobe.cntInc = 1'b1;
          if (cntAtMax) stateNext = SQ_RUN;
        end
        default: stateNext = SQ_HOLD;
      endcase
    end
  end

  always_ff @(negedge xclk or posedge porRst) begin
    if (porRst) state <= SQ_HOLD;
    else        state <= stateNext;
  end

  assign rstPinDriveLow = (state == SQ_HOLD);
  assign cpuRstN        = (state == SQ_RUN) || (state == SQ_STOP) || (state == SQ_WAKE);
  assign ibusClkEn      = (state == SQ_TAIL) || (state == SQ_RUN);

  a_r3_src_forces_pin: assert property (@(negedge xclk) disable iff (porRst)
    anySrc |=> rstPinDriveLow);
  a_r4_cpu_after_pin: assert property (@(negedge xclk) disable iff (porRst)
    cpuRstN |-> !rstPinDriveLow);
  a_r10_stop_bus_off: assert property (@(negedge xclk) disable iff (porRst)
    (ibusClkEn && cpuRstN && stopEnter && !anySrc) |=> (!ibusClkEn && cpuRstN));
  a_r11_bus_off_in_hold: assert property (@(negedge xclk) disable iff (porRst)
    rstPinDriveLow |-> !ibusClkEn);
endmodule

// File: rtl/resetSequencer.sv
module resetSequencer
  import rsqPkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int TAIL_LEN = 64,
  parameter int STS_W    = 8
) (
  input  logic             xclk,
  input  logic             porRst,
  input  logic             lviTrip,
  input  logic             lviPwrDisable,
  input  logic             lviRstDisable,
  input  logic             accValid,
  input  logic             accIsFetch,
  input  logic             accUnmapped,
  input  logic             rstPinIn,
  input  logic             stopEnter,
  input  logic             wakeUp,
  input  logic             stsRead,
  output logic             rstPinDriveLow,
  output logic             cpuRstN,
  output logic             ibusClkEn,
  output logic             copTick,
  output logic [STS_W-1:0] stsData
);
  seqStrobe_t strobe;
  logic cntAtMax, cntAtTail;

  rsqControl i_ctrl (
    .xclk(xclk), .porRst(porRst),
    .lviTrip(lviTrip), .lviPwrDisable(lviPwrDisable), .lviRstDisable(lviRstDisable),
    .accValid(accValid), .accIsFetch(accIsFetch), .accUnmapped(accUnmapped),
    .rstPinIn(rstPinIn), .stopEnter(stopEnter), .wakeUp(wakeUp), .stsRead(stsRead),
    .cntAtMax(cntAtMax), .cntAtTail(cntAtTail), .strobe(strobe),
    .rstPinDriveLow(rstPinDriveLow), .cpuRstN(cpuRstN), .ibusClkEn(ibusClkEn)
  );

  rsqDatapath #(.CNT_W(CNT_W), .TAIL_LEN(TAIL_LEN), .STS_W(STS_W)) i_dp (
    .xclk(xclk), .porRst(porRst), .strobe(strobe),
    .cntAtMax(cntAtMax), .cntAtTail(cntAtTail),
    .copTick(copTick), .stsData(stsData)
  );
endmodule

// File: tb/test_resetSequencer.sv
`timescale 1ns/1ps
module test_resetSequencer;
  logic clk = 1'b0;
  logic porRst = 1'b1;
  logic lviTrip = 0, lviPwrDisable = 0, lviRstDisable = 0;
  logic accValid = 0, accIsFetch = 0, accUnmapped = 0;
  logic extLow = 0, stopEnter = 0, wakeUp = 0, stsRead = 0;
  logic rstPinIn, rstPinDriveLow, cpuRstN, ibusClkEn, copTick;
  logic [7:0] stsData;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign rstPinIn = !(rstPinDriveLow || extLow);

  resetSequencer i_resetSequencer (
    .xclk(clk), .porRst(porRst), .lviTrip(lviTrip), .lviPwrDisable(lviPwrDisable),
    .lviRstDisable(lviRstDisable), .accValid(accValid), .accIsFetch(accIsFetch),
    .accUnmapped(accUnmapped), .rstPinIn(rstPinIn), .stopEnter(stopEnter),
    .wakeUp(wakeUp), .stsRead(stsRead), .rstPinDriveLow(rstPinDriveLow),
    .cpuRstN(cpuRstN), .ibusClkEn(ibusClkEn), .copTick(copTick), .stsData(stsData)
  );

  // Reference model: 0 hold, 1 tail, 2 run, 3 stopped, 4 waking
  int mState, mCnt, mSts;
  bit mTick;
  always @(negedge clk or posedge porRst) begin
    if (porRst) begin
      mState = 0; mCnt = 0; mTick = 0; mSts = 1;
    end else begin
      bit lv, il, pn, tk;
      int old;
      lv = lviTrip && !lviPwrDisable && !lviRstDisable;
      il = accValid && accIsFetch && accUnmapped;
      pn = extLow && (mState != 0);
      tk = 0;
      old = mCnt;
      if (lv || il || pn) begin
        mState = 0; mCnt = 0;
      end else if (mState == 3) begin
        mCnt = 0;
        if (wakeUp) mState = 4;
      end else if (mState == 2 && stopEnter) begin
        mState = 3; mCnt = 0;
      end else begin
        tk = (old == 4095);
        mCnt = (old + 1) % 4096;
        if (mState == 0 && old == 4095) mState = 1;
        else if (mState == 1 && old == 63) mState = 2;
        else if (mState == 4 && old == 4095) mState = 2;
      end
      mTick = tk;
      if (stsRead) mSts = 0;
      mSts = mSts | (int'(lv) << 1) | (int'(il) << 2) | (int'(pn) << 3);
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(posedge clk) if (!porRst && !done) begin
    chk("R3 pin", rstPinDriveLow, mState == 0);
    chk("R4 cpu", cpuRstN, mState >= 2);
    chk("R11 ibus", ibusClkEn, (mState == 1) || (mState == 2));
    chk("R2 tick", copTick, mTick);
    chk("R6 sts", stsData, mSts);
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic waitRun(output int pinCycles, output int cpuCycles);
    pinCycles = 0; cpuCycles = 0;
    while (rstPinDriveLow && pinCycles < 6000) begin @(posedge clk); pinCycles++; end
    while (!cpuRstN && cpuCycles < 200) begin @(posedge clk); cpuCycles++; end
  endtask

  initial begin
    int p, c, ticks;
    cyc(3);
    chk("R6 por state", stsData, 8'h01);
    chk("R3 por pin", rstPinDriveLow, 1);
    chk("R4 por cpu", cpuRstN, 0);
    porRst <= 1'b0;
    waitRun(p, c);
    chk("R3 pin hold 4096", p, 4096);
    chk("R4 cpu tail 64", c, 64);
    // R7 read clear
    chk("R7 before read", stsData, 8'h01);
    stsRead <= 1; cyc(1); stsRead <= 0; cyc(1);
    chk("R7 after read", stsData, 8'h00);
    // R5 gated low-voltage
    lviTrip <= 1; lviPwrDisable <= 1; cyc(10);
    chk("R5 pwr disabled pin", rstPinDriveLow, 0);
    lviPwrDisable <= 0; lviRstDisable <= 1; cyc(10);
    chk("R5 rst disabled flag", stsData, 8'h00);
    chk("R5 rst disabled cpu", cpuRstN, 1);
    lviRstDisable <= 0; cyc(20);
    chk("R5 enabled pin", rstPinDriveLow, 1);
    chk("R5 enabled flag", stsData, 8'h02);
    lviTrip <= 0;
    waitRun(p, c);
    chk("R1 R3 clear on fault", p, 4096);
    // R8 data vs fetch
    stsRead <= 1; cyc(1); stsRead <= 0;
    accValid <= 1; accUnmapped <= 1; accIsFetch <= 0; cyc(5);
    chk("R8 data access ignored", cpuRstN, 1);
    chk("R8 data flag", stsData, 8'h00);
    accIsFetch <= 1; cyc(1); accValid <= 0; accIsFetch <= 0; accUnmapped <= 0; cyc(1);
    chk("R8 fetch resets", rstPinDriveLow, 1);
    chk("R8 fetch flag", stsData, 8'h04);
    waitRun(p, c);
    // R9 external pin
    stsRead <= 1; cyc(1); stsRead <= 0;
    extLow <= 1; cyc(3); extLow <= 0; cyc(1);
    chk("R9 ext pin flag", stsData, 8'h08);
    chk("R9 ext pin reset", cpuRstN, 0);
    waitRun(p, c);
    // R7 simultaneous read and new flag
    stsRead <= 1; accValid <= 1; accIsFetch <= 1; accUnmapped <= 1; cyc(1);
    stsRead <= 0; accValid <= 0; accIsFetch <= 0; accUnmapped <= 0; cyc(1);
    chk("R7 new flag survives read", stsData, 8'h04);
    waitRun(p, c);
    // R2 tick count over two periods
    ticks = 0;
    for (int i = 0; i < 8192; i++) begin @(posedge clk); if (copTick) ticks++; end
    chk("R2 two ticks", ticks, 2);
    // R10 stop and wake
    stopEnter <= 1; cyc(1); stopEnter <= 0; cyc(1);
    chk("R10 bus off in stop", ibusClkEn, 0);
    chk("R10 cpu stays out", cpuRstN, 1);
    cyc(100);
    wakeUp <= 1; cyc(1); wakeUp <= 0;
    p = 0;
    while (!ibusClkEn && p < 6000) begin @(posedge clk); p++; end
    chk("R10 wake 4096", p, 4096);
    // R6 power-on clears other flags
    extLow <= 1; cyc(3); extLow <= 0; cyc(2);
    porRst <= 1; cyc(2);
    chk("R6 por only", stsData, 8'h01);
    porRst <= 0;
    waitRun(p, c);
    chk("R3 after second por", p, 4096);
    cyc(5);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule